// File: doc/BRIEF.md
# Serial Flash Command Phase Tracker

This block listens to the bytes a serial flash controller shifts out and labels each byte with the part of the flash command it belongs to. The parts are the opcode, the address bytes, the dummy bytes and the data bytes that follow them. At each command start it treats the next byte as an opcode and looks it up. A known opcode sets how many address and dummy bytes follow and how many data lines (1, 2 or 4) the controller should use. An unknown opcode sends the tracker into a pass-through state, where every later byte is data.

The tracker holds no serializer and no buffer. A controller feeds it one strobe per transmitted byte and one pulse per chip-select assertion. It reads back the current phase, how many bytes are left in that phase, the line count to use, how many clock cycles each dummy byte occupies, and whether the byte now coming back should be thrown away.

All outputs are registered state or plain decodes of that state. They describe the byte that will be transferred next.

Top module: `flash_snoop`

## Requirements
- R1: After reset the phase is pass-through (code 3), remaining is 0, the line count is 1 and the discard flag is low.
- R2: In the cycle after a `cmd_start` pulse the phase is opcode (code 0), remaining is 1 and the line count is 1. A byte strobe in the same cycle as `cmd_start` is ignored.
- R3: Opcodes 0x03, 0x02, 0xA2 and 0x32 lead to the address phase (code 1) with remaining 3. After the third address byte the phase goes straight to pass-through.
- R4: Opcodes 0x0B, 0x3B, 0x6B and 0xBB lead to 3 address bytes, then the dummy phase (code 2) with remaining 1, then pass-through.
- R5: Opcode 0xEB leads to 3 address bytes, then the dummy phase with remaining 2, then pass-through.
- R6: Any other opcode leads to pass-through with remaining 0. The phase and line count then stay unchanged through any number of byte strobes until the next `cmd_start`.
- R7: In the address and dummy phases, remaining drops by one for each byte strobe. Without a strobe or a `cmd_start`, phase, remaining and line count hold their values.
- R8: Opcodes 0xA2 and 0x3B select 2 lines, and 0x32 and 0x6B select 4 lines. For these four the change takes effect only on entry to pass-through, after all address and dummy bytes.
- R9: Opcode 0xBB selects 2 lines and 0xEB selects 4 lines, effective from the cycle right after the opcode byte.
- R10: `dummy_clks` always equals 8 divided by the current line count: 8, 4 or 2.
- R11: `discard` is high in the opcode, address and dummy phases and low in pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse when chip select asserts |
| byte_valid | input | 1 | A byte is being transferred this cycle |
| byte_data | input | 8 | The transmitted byte |
| phase | output | 2 | 0 opcode, 1 address, 2 dummy, 3 pass-through |
| remain | output | CNT_W (2 by default) | Bytes left in the current phase |
| lane_width | output | 3 | Data lines in use: 1, 2 or 4 |
| dummy_clks | output | 4 | Clock cycles per dummy byte |
| discard | output | 1 | The received byte belongs to a non-data phase |

## Verification
A wrong opcode decode shows up on `phase` and `remain` in the cycle right after the opcode byte. It shows as a wrong byte count, a dummy phase that should not be there, or a jump to pass-through. A counter that is off by one moves the pass-through entry by a byte, which `discard` exposes at that same byte. A line-count change applied too early or too late shows on `lane_width` and `dummy_clks`. For immediate opcodes it shows after the opcode byte; for deferred ones it shows after the last dummy or address byte. The bench checks the outputs after every byte strobe, so each fault appears at the first byte whose label it gets wrong.

// File: rtl/flash_snoop_pkg.sv
package flash_snoop_pkg;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_ADDR   = 2'd1,
    PH_DUMMY  = 2'd2,
    PH_PASS   = 2'd3
  } phase_e;

  // line count code: width = 1 << code
  typedef enum logic [1:0] {
    LN_X1 = 2'd0,
    LN_X2 = 2'd1,
    LN_X4 = 2'd2
  } lane_e;

  typedef struct packed {
    logic       known;
    logic [1:0] dummies;
    lane_e      lanes;
    logic       immediate;
  } op_info_t;

  localparam logic [7:0] OP_READ     = 8'h03;
  localparam logic [7:0] OP_PROG     = 8'h02;
  localparam logic [7:0] OP_PROG_X2  = 8'hA2;
  localparam logic [7:0] OP_PROG_X4  = 8'h32;
  localparam logic [7:0] OP_FREAD    = 8'h0B;
  localparam logic [7:0] OP_RD_OX2   = 8'h3B;
  localparam logic [7:0] OP_RD_OX4   = 8'h6B;
  localparam logic [7:0] OP_RD_IOX2  = 8'hBB;
  localparam logic [7:0] OP_RD_IOX4  = 8'hEB;

endpackage

// File: rtl/flash_snoop_opdecode.sv
module flash_snoop_opdecode
  import flash_snoop_pkg::*;
(
  input  logic [7:0] opcode,
  output op_info_t   info
);

  always_comb begin
    info = '{known: 1'b1, dummies: 2'd0, lanes: LN_X1, immediate: 1'b0};
    case (opcode)
      OP_READ, OP_PROG: ;
      OP_PROG_X2: info.lanes = LN_X2;
      OP_PROG_X4: info.lanes = LN_X4;
      OP_FREAD:   info.dummies = 2'd1;
      OP_RD_OX2: begin
        info.dummies = 2'd1;
        info.lanes   = LN_X2;
      end
      OP_RD_OX4: begin
        info.dummies = 2'd1;
        info.lanes   = LN_X4;
      end
      OP_RD_IOX2: begin
        info.dummies   = 2'd1;
        info.lanes     = LN_X2;
        info.immediate = 1'b1;
      end
      OP_RD_IOX4: begin
        info.dummies   = 2'd2;
        info.lanes     = LN_X4;
        info.immediate = 1'b1;
      end
      default: info.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/flash_snoop_lane_ctrl.sv
module flash_snoop_lane_ctrl
  import flash_snoop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_start,
  input  logic     op_accept,
  input  op_info_t info,
  input  logic     enter_pass,
  output lane_e    lanes
);

  lane_e lanes_q, lanes_d;
  lane_e pend_q, pend_d;
  logic  en;

  assign en = cmd_start | op_accept | enter_pass;

  always_comb begin
    lanes_d = lanes_q;
    pend_d  = pend_q;
    if (cmd_start) begin
      lanes_d = LN_X1;
      pend_d  = LN_X1;
    end else begin
      if (op_accept) begin
        pend_d = info.lanes;
        if (info.immediate) lanes_d = info.lanes;
      end
      if (enter_pass) lanes_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lanes_q <= LN_X1;
      pend_q  <= LN_X1;
    end else if (en) begin
      lanes_q <= lanes_d;
      pend_q  <= pend_d;
    end
  end

  assign lanes = lanes_q;

endmodule

// File: rtl/flash_snoop_phase_fsm.sv
module flash_snoop_phase_fsm
  import flash_snoop_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             byte_valid,
  input  op_info_t         info,
  output phase_e           phase,
  output logic [CNT_W-1:0] remain,
  output logic             op_accept,
  output logic             enter_pass
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [1:0]       dum_q, dum_d;
  logic             adv, en;

  assign adv = byte_valid & ~cmd_start;
  assign en  = cmd_start | byte_valid;

  always_comb begin
    phase_d    = phase_q;
    remain_d   = remain_q;
    dum_d      = dum_q;
    op_accept  = 1'b0;
    enter_pass = 1'b0;
    if (cmd_start) begin
      phase_d  = PH_OPCODE;
      remain_d = CNT_W'(1);
      dum_d    = 2'd0;
    end else if (adv) begin
      case (phase_q)
        PH_OPCODE: begin
          if (info.known) begin
            op_accept = 1'b1;
            phase_d   = PH_ADDR;
            remain_d  = CNT_W'(ADDR_BYTES);
            dum_d     = info.dummies;
          end else begin
            phase_d  = PH_PASS;
            remain_d = '0;
          end
        end
        PH_ADDR: begin
          if (remain_q == CNT_W'(1)) begin
            if (dum_q != 2'd0) begin
              phase_d  = PH_DUMMY;
              remain_d = CNT_W'(dum_q);
            end else begin
              phase_d    = PH_PASS;
              remain_d   = '0;
              enter_pass = 1'b1;
            end
          end else begin
            remain_d = remain_q - CNT_W'(1);
          end
        end
        PH_DUMMY: begin
          if (remain_q == CNT_W'(1)) begin
            phase_d    = PH_PASS;
            remain_d   = '0;
            enter_pass = 1'b1;
          end else begin
            remain_d = remain_q - CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_PASS;
      remain_q <= '0;
      dum_q    <= 2'd0;
    end else if (en) begin
      phase_q  <= phase_d;
      remain_q <= remain_d;
      dum_q    <= dum_d;
    end
  end

  assign phase  = phase_q;
  assign remain = remain_q;

endmodule

// File: rtl/flash_snoop.sv
module flash_snoop
  import flash_snoop_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int CNT_W = ($clog2(ADDR_BYTES + 1) > 2) ? $clog2(ADDR_BYTES + 1) : 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic [1:0]       phase,
  output logic [CNT_W-1:0] remain,
  output logic [2:0]       lane_width,
  output logic [3:0]       dummy_clks,
  output logic             discard
);

  op_info_t info;
  phase_e   phase_s;
  lane_e    lanes_s;
  logic     op_accept;
  logic     enter_pass;

  flash_snoop_opdecode u_dec (
    .opcode (byte_data),
    .info   (info)
  );

  flash_snoop_phase_fsm #(
    .ADDR_BYTES (ADDR_BYTES),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .byte_valid (byte_valid),
    .info       (info),
    .phase      (phase_s),
    .remain     (remain),
    .op_accept  (op_accept),
    .enter_pass (enter_pass)
  );

  flash_snoop_lane_ctrl u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .op_accept  (op_accept),
    .info       (info),
    .enter_pass (enter_pass),
    .lanes      (lanes_s)
  );

  assign phase      = phase_s;
  assign discard    = (phase_s != PH_PASS);
  assign lane_width = 3'd1 << lanes_s;
  assign dummy_clks = 4'd8 >> lanes_s;

endmodule

// File: rtl/flash_snoop_chk.sv
module flash_snoop_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             byte_valid,
  input logic [7:0]       byte_data,
  input logic [1:0]       phase,
  input logic [CNT_W-1:0] remain,
  input logic [2:0]       lane_width
);

  assert_start_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (phase == 2'd0 && remain == CNT_W'(1) && lane_width == 3'd1));

  assert_pass_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && !cmd_start) |=> (phase == 2'd3));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_start && !byte_valid) |=> ($stable(phase) && $stable(remain) && $stable(lane_width)));

  assert_addr_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && byte_valid && !cmd_start && remain > CNT_W'(1))
      |=> (phase == 2'd1 && remain == $past(remain) - CNT_W'(1)));

  assert_quad_io_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && byte_valid && !cmd_start && byte_data == 8'hEB)
      |=> (lane_width == 3'd4 && phase == 2'd1));

endmodule

bind flash_snoop flash_snoop_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .phase      (phase),
  .remain     (remain),
  .lane_width (lane_width)
);

// File: tb/tb_flash_snoop.sv
module tb_flash_snoop;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 2;

  logic             clk;
  logic             rst_n;
  logic             cmd_start;
  logic             byte_valid;
  logic [7:0]       byte_data;
  logic [1:0]       phase;
  logic [CNT_W-1:0] remain;
  logic [2:0]       lane_width;
  logic [3:0]       dummy_clks;
  logic             discard;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  flash_snoop dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .phase      (phase),
    .remain     (remain),
    .lane_width (lane_width),
    .dummy_clks (dummy_clks),
    .discard    (discard)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // phase/remain/lanes/dummy_clks/discard all at once
  task automatic chk_all(input string req, input int ph, input int rem, input int ln);
    chk(req, "phase", int'(phase), ph);
    chk(req, "remain", int'(remain), rem);
    chk(req, "lane_width", int'(lane_width), ln);
    chk("R10", "dummy_clks", int'(dummy_clks), 8 / ln);
    chk("R11", "discard", int'(discard), (ph != 3) ? 1 : 0);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  // One complete command with expected dummy count and line counts
  task automatic run_cmd(input string req, input logic [7:0] op, input int dums,
                         input int imm_ln, input int fin_ln);
    pulse_start();
    chk_all("R2", 0, 1, 1);
    send(op);
    chk_all(req, 1, 3, imm_ln);
    for (int i = 0; i < 3; i++) begin
      send(8'h10 + 8'(i));
      if (i < 2) chk_all("R7", 1, 2 - i, imm_ln);
    end
    if (dums > 0) begin
      chk_all(req, 2, dums, imm_ln);
      for (int d = 0; d < dums; d++) begin
        send(8'hFF);
        if (d < dums - 1) chk_all("R7", 2, dums - 1 - d, imm_ln);
      end
    end
    chk_all(req, 3, 0, fin_ln);
    send(8'h55);
    chk_all("R6", 3, 0, fin_ln);
  endtask

  task automatic t_reset();
    chk_all("R1", 3, 0, 1);
  endtask

  task automatic t_no_dummy();
    run_cmd("R3", 8'h03, 0, 1, 1);
    run_cmd("R3", 8'h02, 0, 1, 1);
    run_cmd("R8", 8'hA2, 0, 1, 2);
    run_cmd("R8", 8'h32, 0, 1, 4);
  endtask

  task automatic t_one_dummy();
    run_cmd("R4", 8'h0B, 1, 1, 1);
    run_cmd("R8", 8'h3B, 1, 1, 2);
    run_cmd("R8", 8'h6B, 1, 1, 4);
    run_cmd("R9", 8'hBB, 1, 2, 2);
  endtask

  task automatic t_quad_io();
    run_cmd("R5", 8'hEB, 2, 4, 4);
  endtask

  task automatic t_unknown();
    run_cmd("R8", 8'h6B, 1, 1, 4);
    pulse_start();
    chk_all("R2", 0, 1, 1);
    send(8'h9F);
    chk_all("R6", 3, 0, 1);
    send(8'h03);
    chk_all("R6", 3, 0, 1);
    send(8'hEB);
    chk_all("R6", 3, 0, 1);
  endtask

  task automatic t_start_wins();
    pulse_start();
    send(8'h03);
    chk_all("R3", 1, 3, 1);
    @(negedge clk);
    cmd_start  = 1'b1;
    byte_valid = 1'b1;
    byte_data  = 8'hEB;
    @(negedge clk);
    cmd_start  = 1'b0;
    byte_valid = 1'b0;
    chk_all("R2", 0, 1, 1);
  endtask

  task automatic t_idle_hold();
    pulse_start();
    send(8'hEB);
    send(8'h00);
    repeat (4) @(negedge clk);
    chk_all("R7", 1, 2, 4);
    send(8'h00);
    send(8'h00);
    chk_all("R5", 2, 2, 4);
    repeat (3) @(negedge clk);
    chk_all("R7", 2, 2, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    cmd_start  = 1'b0;
    byte_valid = 1'b0;
    byte_data  = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_dummy();
    t_one_dummy();
    t_quad_io();
    t_unknown();
    t_start_wins();
    t_idle_hold();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule